// File: doc/BRIEF.md
# GPIO Pin Configuration Register Bank

This block is the software-visible register file of a multi-pin general-purpose I/O controller. A simple 32-bit register bus (enable, write enable, byte address, write data, registered read data) reaches two configuration words for every pin and a set of packed registers. Each packed register holds one bit for each of 32 pins. From the stored settings the block drives each pad's output value and output enable. It also exports the per-pin mode, trigger and pull selections to the neighbouring interrupt and pad logic.

Pad inputs pass through a two-stage synchronizer. The synchronized level can be read back in the first configuration word and is also exported. Both the readback and the export are gated by a per-pin input-sense disable, which is set at reset. The packed registers are an ownership map, an interrupt enable map, a read-only view of interrupt status (writing ones there pulses clear requests to the separate detection block), and one global routing word.

Top module: `gpio_cfg_bank`

## Requirements
- R1: After reset, each pin's first configuration word reads 0x0000_0005 (GPIO mode, input). Its second word reads 0x0000_0004 (input sense off). Every pad output enable is 0, the interrupt enable map is 0, the routing word is 0, and ownership bits for existing pins read 1.
- R2: Read data appears on `bus_rdata` in the cycle after a read access (bus_en=1, bus_we=0) and holds until the next read.
- R3: First word, at byte address 0x100+8*n for pin n: bit 31 is the stored output level and drives `pad_out_o[n]`. Bit 4 selects level trigger (1) or edge trigger (0). Bit 3 inverts the trigger polarity. Bit 2 is direction (1 = input). Bit 0 selects GPIO (1) or native function (0). Bits 29..5 and bit 1 read 0.
- R4: Bit 30 of the first word is read-only. Writes to it are ignored. With sensing enabled, it returns the pad input after two clock stages, and so does `in_level_o[n]`.
- R5: Bit 2 of the second word, at 0x104+8*n, disables input sensing. While it is set, bit 30 and `in_level_o[n]` read 0.
- R6: `pad_oe_o[n]` is 1 exactly when bit 0 is 1 and bit 2 is 0 in the first word.
- R7: Bits 1:0 of the second word are the pull selection, exported on `pull_sel_o[2n+1:2n]`.
- R8: In each packed register, pin n sits at group base + 4*(n/32), bit n%32. Ownership is at 0x00, is read/write, and `gpio_avail_o[n]` is its bit ANDed with GPIO mode. Interrupt enable is at 0x90, is read/write, and drives `irq_en_o`.
- R9: The status group at 0x80 reads `irq_stat_i`. A write there raises `irq_clr_o[n]` for exactly one cycle, in the cycle after the write, for each pin whose written bit is 1.
- R10: The routing word at 0x7C is a 32-bit read/write register driving `route_sel_o`.
- R11: Reads of unmapped addresses, of non-word-aligned addresses, of configuration words of pins at index NUM_PINS and above, and of packed bits above the last pin all return 0. Writes to these locations change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after a read |
| pad_in_i | input | NUM_PINS | Asynchronous pad input levels |
| pad_out_o | output | NUM_PINS | Pad output values |
| pad_oe_o | output | NUM_PINS | Pad output enables |
| gpio_mode_o | output | NUM_PINS | 1 = pin in GPIO mode |
| gpio_avail_o | output | NUM_PINS | Pin owned and in GPIO mode |
| trig_level_o | output | NUM_PINS | 1 = level trigger, 0 = edge |
| trig_invert_o | output | NUM_PINS | Trigger polarity inversion |
| pull_sel_o | output | 2*NUM_PINS | Weak pull selection, two bits per pin |
| in_level_o | output | NUM_PINS | Synchronized, sense-gated input level |
| irq_en_o | output | NUM_PINS | Interrupt enable map |
| irq_stat_i | input | NUM_PINS | Interrupt status from the detection block |
| irq_clr_o | output | NUM_PINS | One-cycle clear requests for status bits |
| route_sel_o | output | 32 | Global routing-select word |

## Verification
The bench builds the block with its default NUM_PINS=94 and ADDR_W=12. At this size the third word of each packed group is only partly populated: bits 30 and 31 of that word stand for nonexistent pins 94 and 95. The configuration window also continues past pin 93 inside the address space. Both boundaries are exercised directly, together with the last real pin. Random writes to all pins and groups are compared against a bench model on every exported vector. Pad inputs are changed between accesses and held long enough to cross the two synchronizer stages.

// File: rtl/gpio_cfg_pkg.sv
package gpio_cfg_pkg;
    // Byte offsets of the register groups
    localparam int OFS_OWN   = 'h000;
    localparam int OFS_ROUTE = 'h07C;
    localparam int OFS_STAT  = 'h080;
    localparam int OFS_EN    = 'h090;
    localparam int OFS_CFG   = 'h100;

    // First configuration word fields
    localparam int C1_OUT  = 31;
    localparam int C1_IN   = 30;
    localparam int C1_TRIG = 4;
    localparam int C1_INV  = 3;
    localparam int C1_DIR  = 2;
    localparam int C1_USE  = 0;

    // Second configuration word fields
    localparam int C2_NOSENSE = 2;
endpackage

// File: rtl/gpio_pin_cfg.sv
module gpio_pin_cfg (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_w1,
    input  logic        wr_w2,
    input  logic        wd_out,
    input  logic        wd_trig,
    input  logic        wd_inv,
    input  logic        wd_dir,
    input  logic        wd_use,
    input  logic        wd_nosense,
    input  logic [1:0]  wd_pull,
    input  logic        pad_in,
    output logic [31:0] rd_w1,
    output logic [31:0] rd_w2,
    output logic        pad_out,
    output logic        pad_oe,
    output logic        use_gpio,
    output logic        trig_level,
    output logic        trig_inv,
    output logic [1:0]  pull,
    output logic        sensed
);
    logic       out_q, trig_q, inv_q, dir_q, use_q, nosense_q;
    logic [1:0] pull_q;
    logic [1:0] sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q     <= 1'b0;
            trig_q    <= 1'b0;
            inv_q     <= 1'b0;
            dir_q     <= 1'b1;
            use_q     <= 1'b1;
            nosense_q <= 1'b1;
            pull_q    <= 2'b00;
            sync_q    <= 2'b00;
        end else begin
            sync_q <= {sync_q[0], pad_in};
            if (wr_w1) begin
                out_q  <= wd_out;
                trig_q <= wd_trig;
                inv_q  <= wd_inv;
                dir_q  <= wd_dir;
                use_q  <= wd_use;
            end
            if (wr_w2) begin
                nosense_q <= wd_nosense;
                pull_q    <= wd_pull;
            end
        end
    end

    always_comb begin
        sensed     = sync_q[1] & ~nosense_q;
        pad_out    = out_q;
        pad_oe     = use_q & ~dir_q;
        use_gpio   = use_q;
        trig_level = trig_q;
        trig_inv   = inv_q;
        pull       = pull_q;
        rd_w1      = {out_q, sensed, 25'd0, trig_q, inv_q, dir_q, 1'b0, use_q};
        rd_w2      = {29'd0, nosense_q, pull_q};
    end

    // R6: native mode never drives the pad
    assert_oe_native_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_w1 && !wd_use |=> !pad_oe);
    // R6: GPIO output configuration drives the pad
    assert_oe_output_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_w1 && wd_use && !wd_dir |=> pad_oe);
    // R5: sense disable silences both views of the input
    assert_sense_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_w2 && wd_nosense |=> !sensed && !rd_w1[30]);
    // R3: written output level reaches the pad
    assert_out_level_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_w1 |=> pad_out == $past(wd_out));
endmodule

// File: rtl/gpio_bitmap_bank.sv
module gpio_bitmap_bank #(
    parameter int NUM_BITS   = 94,
    parameter int NWORDS     = 3,
    parameter int WSEL_W     = 2,
    parameter bit RESET_ONES = 1'b0
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [WSEL_W-1:0]        wr_word,
    input  logic [31:0]              wdata,
    output logic [NWORDS*32-1:0]     bits
);
    localparam int TOTAL = NWORDS * 32;
    localparam logic [TOTAL-1:0] VALID = {TOTAL{1'b1}} >> (TOTAL - NUM_BITS);
    localparam logic [TOTAL-1:0] RST   = RESET_ONES ? VALID : '0;

    for (genvar w = 0; w < NWORDS; w++) begin : g_word
        logic [31:0] q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                q <= RST[w*32 +: 32];
            else if (wr_en && wr_word == WSEL_W'(w))
                q <= wdata & VALID[w*32 +: 32];
        end
        assign bits[w*32 +: 32] = q;

        // R8: a write lands in its word; bits past the last pin stay clear (R11)
        assert_bank_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
            wr_en && wr_word == WSEL_W'(w) |=> q == ($past(wdata) & VALID[w*32 +: 32]));
    end
endmodule

// File: rtl/gpio_cfg_bank.sv
module gpio_cfg_bank
    import gpio_cfg_pkg::*;
#(
    parameter int NUM_PINS = 94,
    parameter int ADDR_W   = 12
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_en,
    input  logic                  bus_we,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [31:0]           bus_wdata,
    output logic [31:0]           bus_rdata,
    input  logic [NUM_PINS-1:0]   pad_in_i,
    output logic [NUM_PINS-1:0]   pad_out_o,
    output logic [NUM_PINS-1:0]   pad_oe_o,
    output logic [NUM_PINS-1:0]   gpio_mode_o,
    output logic [NUM_PINS-1:0]   gpio_avail_o,
    output logic [NUM_PINS-1:0]   trig_level_o,
    output logic [NUM_PINS-1:0]   trig_invert_o,
    output logic [2*NUM_PINS-1:0] pull_sel_o,
    output logic [NUM_PINS-1:0]   in_level_o,
    output logic [NUM_PINS-1:0]   irq_en_o,
    input  logic [NUM_PINS-1:0]   irq_stat_i,
    output logic [NUM_PINS-1:0]   irq_clr_o,
    output logic [31:0]           route_sel_o
);
    localparam int NWORDS = (NUM_PINS + 31) / 32;
    localparam int TOTAL  = NWORDS * 32;
    localparam int WA_W   = ADDR_W - 2;
    localparam int SLOT_W = WA_W - 1;
    localparam int WSEL_W = (NWORDS > 1) ? $clog2(NWORDS) : 1;

    localparam logic [WA_W-1:0] WA_OWN   = WA_W'(OFS_OWN / 4);
    localparam logic [WA_W-1:0] WA_ROUTE = WA_W'(OFS_ROUTE / 4);
    localparam logic [WA_W-1:0] WA_STAT  = WA_W'(OFS_STAT / 4);
    localparam logic [WA_W-1:0] WA_EN    = WA_W'(OFS_EN / 4);
    localparam logic [WA_W-1:0] WA_CFG   = WA_W'(OFS_CFG / 4);

    // ---------------- address decode ----------------
    logic [WA_W-1:0]   wa, own_off, stat_off, en_off, cfg_off;
    logic [SLOT_W-1:0] cfg_slot;
    logic aligned, own_hit, stat_hit, en_hit, route_hit, cfg_hit, any_hit;
    logic wr, rd;

    always_comb begin
        wa        = bus_addr[ADDR_W-1:2];
        aligned   = (bus_addr[1:0] == 2'b00);
        own_off   = wa - WA_OWN;
        stat_off  = wa - WA_STAT;
        en_off    = wa - WA_EN;
        cfg_off   = wa - WA_CFG;
        cfg_slot  = cfg_off[WA_W-1:1];
        own_hit   = aligned && (wa >= WA_OWN)  && (own_off  < WA_W'(NWORDS));
        stat_hit  = aligned && (wa >= WA_STAT) && (stat_off < WA_W'(NWORDS));
        en_hit    = aligned && (wa >= WA_EN)   && (en_off   < WA_W'(NWORDS));
        route_hit = aligned && (wa == WA_ROUTE);
        cfg_hit   = aligned && (wa >= WA_CFG)  && (cfg_slot < SLOT_W'(NUM_PINS));
        any_hit   = own_hit | stat_hit | en_hit | route_hit | cfg_hit;
        wr        = bus_en & bus_we;
        rd        = bus_en & ~bus_we;
    end

    // ---------------- packed registers ----------------
    logic [TOTAL-1:0] own_vec, en_vec, stat_pad;

    gpio_bitmap_bank #(.NUM_BITS(NUM_PINS), .NWORDS(NWORDS), .WSEL_W(WSEL_W), .RESET_ONES(1'b1)) u_own (
        .clk(clk), .rst_n(rst_n), .wr_en(wr & own_hit),
        .wr_word(own_off[WSEL_W-1:0]), .wdata(bus_wdata), .bits(own_vec));

    gpio_bitmap_bank #(.NUM_BITS(NUM_PINS), .NWORDS(NWORDS), .WSEL_W(WSEL_W), .RESET_ONES(1'b0)) u_en (
        .clk(clk), .rst_n(rst_n), .wr_en(wr & en_hit),
        .wr_word(en_off[WSEL_W-1:0]), .wdata(bus_wdata), .bits(en_vec));

    always_comb begin
        stat_pad = '0;
        stat_pad[NUM_PINS-1:0] = irq_stat_i;
    end

    // ---------------- per-pin configuration ----------------
    logic [31:0] pin_w1 [NUM_PINS];
    logic [31:0] pin_w2 [NUM_PINS];

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        logic sel;
        assign sel = cfg_hit && (cfg_slot == SLOT_W'(p));
        gpio_pin_cfg u_pin (
            .clk(clk), .rst_n(rst_n),
            .wr_w1(wr & sel & ~cfg_off[0]),
            .wr_w2(wr & sel & cfg_off[0]),
            .wd_out(bus_wdata[C1_OUT]), .wd_trig(bus_wdata[C1_TRIG]),
            .wd_inv(bus_wdata[C1_INV]), .wd_dir(bus_wdata[C1_DIR]),
            .wd_use(bus_wdata[C1_USE]), .wd_nosense(bus_wdata[C2_NOSENSE]),
            .wd_pull(bus_wdata[1:0]), .pad_in(pad_in_i[p]),
            .rd_w1(pin_w1[p]), .rd_w2(pin_w2[p]),
            .pad_out(pad_out_o[p]), .pad_oe(pad_oe_o[p]),
            .use_gpio(gpio_mode_o[p]), .trig_level(trig_level_o[p]),
            .trig_inv(trig_invert_o[p]), .pull(pull_sel_o[2*p +: 2]),
            .sensed(in_level_o[p]));
    end

    // ---------------- read mux ----------------
    logic [31:0] rd_val;
    always_comb begin
        rd_val = '0;
        for (int w = 0; w < NWORDS; w++) begin
            if (own_hit  && own_off  == WA_W'(w)) rd_val = own_vec[w*32 +: 32];
            if (stat_hit && stat_off == WA_W'(w)) rd_val = stat_pad[w*32 +: 32];
            if (en_hit   && en_off   == WA_W'(w)) rd_val = en_vec[w*32 +: 32];
        end
        if (route_hit) rd_val = route_sel_o;
        for (int p = 0; p < NUM_PINS; p++)
            if (cfg_hit && cfg_slot == SLOT_W'(p))
                rd_val = cfg_off[0] ? pin_w2[p] : pin_w1[p];
    end

    // ---------------- registers at the top ----------------
    logic [NUM_PINS-1:0] clr_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_rdata   <= '0;
            route_sel_o <= '0;
            clr_q       <= '0;
        end else begin
            if (rd) bus_rdata <= rd_val;
            if (wr && route_hit) route_sel_o <= bus_wdata;
            clr_q <= '0;
            for (int b = 0; b < NUM_PINS; b++)
                if (wr && stat_hit && stat_off == WA_W'(b / 32))
                    clr_q[b] <= bus_wdata[b % 32];
        end
    end

    assign irq_clr_o    = clr_q;
    assign irq_en_o     = en_vec[NUM_PINS-1:0];
    assign gpio_avail_o = own_vec[NUM_PINS-1:0] & gpio_mode_o;

    // R11: a read that decodes nowhere returns zero
    assert_unmapped_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rd && !any_hit |=> bus_rdata == 32'd0);
    // R2: read data holds between reads
    assert_rdata_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> $stable(bus_rdata));
    // R10: routing word captures write data
    assert_route_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wr && route_hit |=> route_sel_o == $past(bus_wdata));
    // R9: clear requests last one cycle only
    assert_clr_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr && stat_hit) |=> irq_clr_o == '0);
endmodule

// File: tb/gpio_cfg_bank_tb.sv
module gpio_cfg_bank_tb;
    localparam int NP = 94;
    localparam int AW = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_en = 1'b0, bus_we = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic [NP-1:0] pad_in = '0, irq_stat = '0;
    logic [NP-1:0] pad_out, pad_oe, mode, avail, trig, inv, inlvl, irq_en, irq_clr;
    logic [2*NP-1:0] pull;
    logic [31:0] route;

    always #5 clk = ~clk;

    gpio_cfg_bank #(.NUM_PINS(NP), .ADDR_W(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_in_i(pad_in), .pad_out_o(pad_out), .pad_oe_o(pad_oe),
        .gpio_mode_o(mode), .gpio_avail_o(avail), .trig_level_o(trig),
        .trig_invert_o(inv), .pull_sel_o(pull), .in_level_o(inlvl),
        .irq_en_o(irq_en), .irq_stat_i(irq_stat), .irq_clr_o(irq_clr),
        .route_sel_o(route));

    int checks = 0, errors = 0;
    bit done = 0;

    // bench model
    logic [NP-1:0] m_out, m_trig, m_inv, m_dir, m_use, m_nos;
    logic [2*NP-1:0] m_pull;
    logic [95:0] m_own, m_en;
    logic [31:0] m_route;

    task automatic chk(string tag, logic [191:0] act, logic [191:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_read(logic [AW-1:0] a);
        int w;
        int slot;
        logic sensed;
        if (a[1:0] != 2'b00) return 32'd0;
        w = int'(a) / 4;
        if (w <= 2) return m_own[w*32 +: 32];
        if (w == 'h1F) return m_route;
        if (w >= 'h20 && w <= 'h22) begin
            logic [95:0] s = '0;
            s[NP-1:0] = irq_stat;
            return s[(w-'h20)*32 +: 32];
        end
        if (w >= 'h24 && w <= 'h26) return m_en[(w-'h24)*32 +: 32];
        if (w >= 'h40) begin
            slot = (w - 'h40) / 2;
            if (slot >= NP) return 32'd0;
            if (w % 2 == 1) return {29'd0, m_nos[slot], m_pull[2*slot +: 2]};
            sensed = pad_in[slot] & ~m_nos[slot];
            return {m_out[slot], sensed, 25'd0, m_trig[slot], m_inv[slot],
                    m_dir[slot], 1'b0, m_use[slot]};
        end
        return 32'd0;
    endfunction

    task automatic model_write(logic [AW-1:0] a, logic [31:0] d);
        int w;
        int slot;
        if (a[1:0] != 2'b00) return;
        w = int'(a) / 4;
        if (w <= 2) begin
            m_own[w*32 +: 32] = d;
            m_own[95:NP] = '0;
        end else if (w == 'h1F) m_route = d;
        else if (w >= 'h24 && w <= 'h26) begin
            m_en[(w-'h24)*32 +: 32] = d;
            m_en[95:NP] = '0;
        end else if (w >= 'h40) begin
            slot = (w - 'h40) / 2;
            if (slot < NP) begin
                if (w % 2 == 0) begin
                    m_out[slot] = d[31]; m_trig[slot] = d[4]; m_inv[slot] = d[3];
                    m_dir[slot] = d[2];  m_use[slot]  = d[0];
                end else begin
                    m_nos[slot] = d[2]; m_pull[2*slot +: 2] = d[1:0];
                end
            end
        end
    endtask

    task automatic bus_write(logic [AW-1:0] a, logic [31:0] d);
        @(negedge clk);
        bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 0; bus_we = 0;
        model_write(a, d);
    endtask

    task automatic bus_read_chk(logic [AW-1:0] a, string tag);
        logic [31:0] e;
        @(negedge clk);
        bus_en = 1; bus_we = 0; bus_addr = a;
        e = exp_read(a);
        @(negedge clk);
        bus_en = 0;
        chk(tag, {160'd0, bus_rdata}, {160'd0, e});
    endtask

    task automatic chk_outs(string tag);
        logic [NP-1:0] e_oe, e_in;
        e_oe = m_use & ~m_dir;
        e_in = pad_in & ~m_nos;
        chk({tag, " R6 oe"},    {98'd0, pad_oe}, {98'd0, e_oe});
        chk({tag, " R3 out"},   {98'd0, pad_out}, {98'd0, m_out});
        chk({tag, " R3 mode"},  {98'd0, mode, trig, inv}, {98'd0, m_use, m_trig, m_inv});
        chk({tag, " R7 pull"},  {4'd0, pull}, {4'd0, m_pull});
        chk({tag, " R4 inlvl"}, {98'd0, inlvl}, {98'd0, e_in});
        chk({tag, " R8 en/avail"}, {4'd0, irq_en, avail}, {4'd0, m_en[NP-1:0], m_own[NP-1:0] & m_use});
    endtask

    task automatic settle_pads(logic [NP-1:0] v);
        @(negedge clk);
        pad_in = v;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        m_out = '0; m_trig = '0; m_inv = '0; m_dir = '1; m_use = '1; m_nos = '1;
        m_pull = '0; m_own = '0; m_own[NP-1:0] = '1; m_en = '0; m_route = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1 reset state
        chk_outs("R1 reset");
        chk("R1 route", {160'd0, route}, 192'd0);
        bus_read_chk(12'h100, "R1 pin0 w1");
        bus_read_chk(12'h104, "R1 pin0 w2");
        bus_read_chk(12'h3E8, "R1 pin93 w1");
        bus_read_chk(12'h008, "R1 own word2");
        bus_read_chk(12'h090, "R1 en word0");

        // R3/R6 output config on pin 5, with bit 30 written (R4 ignored)
        bus_write(12'h128, 32'hC000_0019);
        chk_outs("R3 pin5 out");
        bus_read_chk(12'h128, "R4 bit30 write ignored");

        // R7 pull + R4 sensing
        bus_write(12'h12C, 32'h0000_0002);
        settle_pads(94'd1 << 5);
        chk_outs("R4 sense on");
        bus_read_chk(12'h128, "R4 level read");
        // R5 disable sensing
        bus_write(12'h12C, 32'h0000_0005);
        chk_outs("R5 sense off");
        bus_read_chk(12'h128, "R5 level zero");
        // R6 native mode
        bus_write(12'h128, 32'h8000_0000);
        chk_outs("R6 native");

        // R8 packed groups, last word partial (R11)
        bus_write(12'h098, 32'hFFFF_FFFF);
        chk_outs("R8 en word2");
        bus_read_chk(12'h098, "R11 en upper bits");
        bus_write(12'h000, 32'hFFFF_FFF7);
        chk_outs("R8 own pin3");

        // R9 status view and clear pulse
        irq_stat = {30'h2AAA_AAAA, 32'h1234_5678, 32'h8000_0001};
        bus_read_chk(12'h080, "R9 stat0");
        bus_read_chk(12'h088, "R9 stat2");
        bus_write(12'h084, 32'h0000_0005);
        chk("R9 clr pulse", {98'd0, irq_clr}, {98'd0, (94'd5 << 32)});
        @(negedge clk);
        chk("R9 clr ends", {98'd0, irq_clr}, 192'd0);

        // R10 routing
        bus_write(12'h07C, 32'hA5A5_0F0F);
        chk("R10 route", {160'd0, route}, {160'd0, 32'hA5A5_0F0F});
        bus_read_chk(12'h07C, "R10 route read");

        // R11 unmapped / out of range / misaligned
        bus_write(12'h3F0, 32'hFFFF_FFFF);
        bus_write(12'h3F4, 32'h0000_0000);
        bus_write(12'h101, 32'h8000_0000);
        bus_write(12'h0A0, 32'hFFFF_FFFF);
        chk_outs("R11 writes ignored");
        bus_read_chk(12'h3F0, "R11 pin94");
        bus_read_chk(12'h101, "R11 misaligned");
        bus_read_chk(12'h0A0, "R11 hole");
        bus_read_chk(12'h7FC, "R11 far");

        // random phase
        for (int i = 0; i < 400; i++) begin
            int kind = $urandom % 8;
            int p = $urandom % NP;
            logic [31:0] d = $urandom;
            logic [AW-1:0] a;
            case (kind)
                0, 1: a = AW'(12'h100 + 8 * p);
                2:    a = AW'(12'h104 + 8 * p);
                3:    a = AW'(12'h090 + 4 * ($urandom % 3));
                4:    a = AW'(4 * ($urandom % 3));
                5:    a = AW'($urandom);
                default: a = AW'(12'h100 + 8 * p + 4 * ($urandom % 2));
            endcase
            if (kind == 7) begin
                irq_stat = {$urandom, $urandom, $urandom};
                bus_read_chk(a, "R2 random read");
            end else if (kind == 6) begin
                settle_pads({$urandom, $urandom, $urandom});
                bus_read_chk(a, "R4 random pad read");
            end else begin
                bus_write(a, d);
                chk_outs("R3 random write");
                bus_read_chk(a, "R2 random readback");
            end
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule